// File: doc/BRIEF.md
# Quad Potentiometer Setting Store

This block keeps the settings for four digitally controlled potentiometers. Each pot has one volatile working register that drives its wiper and four retained setting slots. A serial front end decodes host traffic into single-cycle commands for this block. The commands read or write the working register, read or write a slot, or move a value between a slot and the working register. A move works on one pot or on all four pots at once. All registers are 8 bits wide. The two upper bits, which select cascade and disable the wiper, are kept and moved together with the 6-bit tap position.

The retained slots are flops with a preset contents parameter, and reset does not clear them. Reset reloads each working register from slot 0 of its own pot. Any command that changes retained data starts a busy window, which models the program time of a nonvolatile cell. During that window further retained-data changes are refused. Working-register traffic and reads are still served at once.

Command codes on `cmd_op`: 0 read working register, 1 write working register, 2 read slot, 3 write slot, 4 load slot to working register, 5 store working register to slot, 6 load slot to working register on all pots, 7 store working register to slot on all pots. Slot `r` of pot `p` is byte `p*4+r` of `DR_PRESET`. Working register `p` is `wcr_out[8*p+7:8*p]`.

Top module: `trim_reg_bank`

## Requirements
- R1: While `rst_n` is low the block accepts no command (`cmd_ack` low). Reset leaves every slot unchanged. One cycle after reset is applied, every working register equals slot 0 of its own pot, `busy` is low and `rd_valid` is low.
- R2: An accepted code 1 sets working register `cmd_pot` to all 8 bits of `cmd_wdata` on the next clock edge. The other working registers do not change.
- R3: An accepted code 0 or code 2 puts the working register or slot (`cmd_pot`, `cmd_reg`) on `rd_data` on the next edge. `rd_valid` is high for exactly that one cycle.
- R4: An accepted code 3 writes `cmd_wdata` into slot `cmd_reg` of pot `cmd_pot` and starts the busy window.
- R5: An accepted code 4 copies slot `cmd_reg` of pot `cmd_pot` into that pot's working register on the next edge. The other pots do not change.
- R6: An accepted code 5 copies working register `cmd_pot` into slot `cmd_reg` of the same pot and starts the busy window.
- R7: An accepted code 6 copies slot `cmd_reg` of every pot into that pot's working register on the same edge.
- R8: An accepted code 7 copies every working register into slot `cmd_reg` of its own pot and starts the busy window.
- R9: `busy` rises on the edge that accepts code 3, 5 or 7 and stays high for exactly `BUSY_CYCLES` cycles. `busy` never rises at any other time.
- R10: While `busy` is high, codes 3, 5 and 7 get `cmd_ack` low and leave every slot unchanged. Codes 0, 1, 2, 4 and 6 get `cmd_ack` high and take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; triggers the slot-0 recall |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (0 to 7) |
| cmd_pot | input | 2 | Pot index |
| cmd_reg | input | 2 | Slot index |
| cmd_wdata | input | 8 | Write data for codes 1 and 3 |
| cmd_ack | output | 1 | The command is accepted this cycle |
| busy | output | 1 | Modelled retained-write window in progress |
| rd_valid | output | 1 | `rd_data` holds the result of a read |
| rd_data | output | 8 | Read result |
| wcr_out | output | 32 | The four working registers, pot 0 in the low byte |

## Verification
The sharpest overlap is a retained-data change that arrives in the final cycle of a busy window, against the same change one cycle later. The bench counts the cycles exactly, issues a slot write while `busy` is still high on its last count and expects a refusal, then repeats the write on the following cycle and expects it to be accepted. A second overlap is volatile traffic during a busy window: a working-register write arrives inside the window and must take effect on the next edge without disturbing the slots. Every result is judged against a software model of all 20 registers, through the read commands and `wcr_out`.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [2:0] {
        OP_RD_WCR = 3'd0,
        OP_WR_WCR = 3'd1,
        OP_RD_DR  = 3'd2,
        OP_WR_DR  = 3'd3,
        OP_LOAD   = 3'd4,
        OP_STORE  = 3'd5,
        OP_GLOAD  = 3'd6,
        OP_GSTORE = 3'd7
    } trim_op_e;

    typedef struct packed {
        logic rd_wcr;
        logic rd_dr;
        logic wr_wcr;
        logic wr_dr;
        logic load;
        logic store;
        logic gload;
        logic gstore;
    } op_dec_t;

endpackage

// File: rtl/trim_cmd_decode.sv
module trim_cmd_decode
    import trim_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    input  logic       busy,
    output op_dec_t    dec,
    output logic       ack
);

    op_dec_t raw;
    logic    nv_change;

    always_comb begin
        raw = '0;
        case (trim_op_e'(op))
            OP_RD_WCR: raw.rd_wcr = 1'b1;
            OP_WR_WCR: raw.wr_wcr = 1'b1;
            OP_RD_DR:  raw.rd_dr  = 1'b1;
            OP_WR_DR:  raw.wr_dr  = 1'b1;
            OP_LOAD:   raw.load   = 1'b1;
            OP_STORE:  raw.store  = 1'b1;
            OP_GLOAD:  raw.gload  = 1'b1;
            default:   raw.gstore = 1'b1;
        endcase
        nv_change = raw.wr_dr | raw.store | raw.gstore;
        ack       = valid && !(nv_change && busy);
        dec       = ack ? raw : '0;
    end

endmodule

// File: rtl/trim_busy_timer.sv
module trim_busy_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R9
    AST_BUSY_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9

endmodule

// File: rtl/trim_reg_bank.sv
module trim_reg_bank
    import trim_pkg::*;
#(
    parameter int NUM_POTS    = 4,
    parameter int NUM_REGS    = 4,
    parameter int DW          = 8,
    parameter int BUSY_CYCLES = 1250000,
    parameter logic [NUM_POTS*NUM_REGS*DW-1:0] DR_PRESET =
        128'hAFAEADACABAAA9A8A7A6A5A4A3A2A1A0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [$clog2(NUM_POTS)-1:0] cmd_pot,
    input  logic [$clog2(NUM_REGS)-1:0] cmd_reg,
    input  logic [DW-1:0]               cmd_wdata,
    output logic                        cmd_ack,
    output logic                        busy,
    output logic                        rd_valid,
    output logic [DW-1:0]               rd_data,
    output logic [NUM_POTS*DW-1:0]      wcr_out
);

    localparam int PW     = $clog2(NUM_POTS);
    localparam int RW     = $clog2(NUM_REGS);
    localparam int NSLOTS = NUM_POTS * NUM_REGS;

    typedef struct packed {
        logic [NUM_POTS-1:0][DW-1:0] wcr;
        logic [DW-1:0]               rd;
        logic                        rd_vld;
    } st_t;

    st_t  st_d, st_q, st_rst;
    logic [NSLOTS-1:0][DW-1:0] dr_d;
    logic [NSLOTS-1:0][DW-1:0] dr_q = DR_PRESET;

    op_dec_t          dec;
    logic             nv_start;
    logic [PW+RW-1:0] sel;

    trim_cmd_decode u_dec (
        .valid (cmd_valid & rst_n),
        .op    (cmd_op),
        .busy  (busy),
        .dec   (dec),
        .ack   (cmd_ack)
    );

    assign nv_start = dec.wr_dr | dec.store | dec.gstore;

    trim_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (busy)
    );

    // slot index: pot in the high bits, slot in the low bits
    assign sel = {cmd_pot, cmd_reg};

    always_comb begin
        st_d        = st_q;
        dr_d        = dr_q;
        st_d.rd_vld = 1'b0;
        if (dec.rd_wcr) begin
            st_d.rd     = st_q.wcr[cmd_pot];
            st_d.rd_vld = 1'b1;
        end
        if (dec.rd_dr) begin
            st_d.rd     = dr_q[sel];
            st_d.rd_vld = 1'b1;
        end
        if (dec.wr_wcr) st_d.wcr[cmd_pot] = cmd_wdata;
        if (dec.load)   st_d.wcr[cmd_pot] = dr_q[sel];
        if (dec.wr_dr)  dr_d[sel] = cmd_wdata;
        if (dec.store)  dr_d[sel] = st_q.wcr[cmd_pot];
        for (int p = 0; p < NUM_POTS; p++) begin
            if (dec.gload)  st_d.wcr[p] = dr_q[p*NUM_REGS + int'(cmd_reg)];
            if (dec.gstore) dr_d[p*NUM_REGS + int'(cmd_reg)] = st_q.wcr[p];
        end
    end

    always_comb begin
        st_rst = '0;
        for (int p = 0; p < NUM_POTS; p++)
            st_rst.wcr[p] = dr_q[p*NUM_REGS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        dr_q <= dr_d;
    end

    assign rd_valid = st_q.rd_vld;
    assign rd_data  = st_q.rd;
    assign wcr_out  = st_q.wcr;

    AST_WCR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ack && cmd_op == OP_WR_WCR)
        |=> (st_q.wcr[$past(cmd_pot)] == $past(cmd_wdata))); // R2
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ack && (cmd_op == OP_RD_WCR || cmd_op == OP_RD_DR))
        |=> rd_valid); // R3
    AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid &&
         (cmd_op == OP_WR_DR || cmd_op == OP_STORE || cmd_op == OP_GSTORE))
        |=> $stable(dr_q)); // R10

endmodule

// File: tb/test_trim_reg_bank.sv
`timescale 1ns/1ps
module test_trim_reg_bank;

    localparam int BC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [1:0] cmd_pot = '0;
    logic [1:0] cmd_reg = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_ack, busy, rd_valid;
    logic [7:0] rd_data;
    logic [31:0] wcr_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_wcr [4];
    logic [7:0] m_dr  [16];

    always #2 clk = ~clk;

    trim_reg_bank #(.BUSY_CYCLES(BC)) i_trim_reg_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .wcr_out(wcr_out)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_wcr(input string tag);
        for (int q = 0; q < 4; q++)
            chk(wcr_out[8*q +: 8] == m_wcr[q], tag, wcr_out[8*q +: 8], m_wcr[q]);
    endtask

    // called at a negedge; returns at the next negedge with results visible
    task automatic issue(input int op, input int p, input int r, input logic [7:0] d,
                         input logic exp_ack, input string tag);
        int idx;
        logic [7:0] exp_rd;
        idx = p*4 + r;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pot = 2'(p); cmd_reg = 2'(r); cmd_wdata = d;
        #1;
        chk(cmd_ack == exp_ack, tag, cmd_ack, exp_ack);
        exp_rd = (op == 0) ? m_wcr[p] : m_dr[idx];
        if (exp_ack) begin
            case (op)
                1: m_wcr[p] = d;
                3: m_dr[idx] = d;
                4: m_wcr[p] = m_dr[idx];
                5: m_dr[idx] = m_wcr[p];
                6: for (int q = 0; q < 4; q++) m_wcr[q] = m_dr[q*4 + r];
                7: for (int q = 0; q < 4; q++) m_dr[q*4 + r] = m_wcr[q];
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_ack && (op == 0 || op == 2)) begin
            chk(rd_valid == 1'b1, tag, rd_valid, 1);
            chk(rd_data == exp_rd, tag, rd_data, exp_rd);
        end else begin
            chk(rd_valid == 1'b0, tag, rd_valid, 0);
        end
        chk_wcr(tag);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int q = 0; q < 4; q++) m_wcr[q] = m_dr[q*4];
        chk(cmd_ack == 1'b0, "R1 ack low in reset", cmd_ack, 0);
        chk_wcr("R1 recall from slot 0");
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_wcr_rw();
        issue(1, 1, 0, 8'hC5, 1'b1, "R2 write working reg");
        issue(0, 1, 0, 8'h00, 1'b1, "R3 read working reg");
        @(negedge clk);
        chk(rd_valid == 1'b0, "R3 single-cycle rd_valid", rd_valid, 0);
        issue(2, 3, 1, 8'h00, 1'b1, "R3 read slot");
    endtask

    task automatic t_dr_write_busy();
        int n;
        n = 0;
        issue(3, 3, 2, 8'h5A, 1'b1, "R4 write slot");
        for (int k = 0; k < 100 && busy; k++) begin
            n++;
            @(negedge clk);
        end
        chk(n == BC, "R9 busy length", n, BC);
        issue(2, 3, 2, 8'h00, 1'b1, "R4 slot read back");
    endtask

    task automatic t_reject_and_edge();
        issue(3, 0, 1, 8'h11, 1'b1, "R4 write slot p0 r1");
        issue(3, 0, 1, 8'h22, 1'b0, "R10 write slot refused");
        issue(5, 0, 1, 8'h00, 1'b0, "R10 store refused");
        issue(7, 0, 1, 8'h00, 1'b0, "R10 global store refused");
        issue(1, 2, 0, 8'h4E, 1'b1, "R10 working write during busy");
        issue(6, 0, 0, 8'h00, 1'b1, "R10 global load during busy");
        issue(2, 0, 1, 8'h00, 1'b1, "R10 slot unchanged");
        // 7 issues so far; busy still high at the 12th negedge after the first accept
        for (int k = 0; k < BC - 7; k++) @(negedge clk);
        chk(busy == 1'b1, "R9 busy in last cycle", busy, 1);
        issue(3, 2, 2, 8'h33, 1'b0, "R10 refused in last busy cycle");
        chk(busy == 1'b0, "R9 busy ends", busy, 0);
        issue(3, 2, 2, 8'h33, 1'b1, "R9 accepted right after busy");
        wait_idle();
    endtask

    task automatic t_load_store();
        issue(4, 2, 3, 8'h00, 1'b1, "R5 load one pot");
        issue(1, 1, 0, 8'h3C, 1'b1, "R2 write before store");
        issue(5, 1, 0, 8'h00, 1'b1, "R6 store one pot");
        chk(busy == 1'b1, "R6 store starts busy", busy, 1);
        wait_idle();
        issue(2, 1, 0, 8'h00, 1'b1, "R6 stored slot");
    endtask

    task automatic t_global();
        issue(6, 0, 1, 8'h00, 1'b1, "R7 global load slot 1");
        for (int q = 0; q < 4; q++) issue(1, q, 0, 8'(8'h81 + q*8'h11), 1'b1, "R2 set pots");
        issue(7, 0, 2, 8'h00, 1'b1, "R8 global store slot 2");
        chk(busy == 1'b1, "R8 global store starts busy", busy, 1);
        wait_idle();
        for (int q = 0; q < 4; q++) issue(2, q, 2, 8'h00, 1'b1, "R8 global stored slot");
        for (int q = 0; q < 4; q++) issue(2, q, 3, 8'h00, 1'b1, "R8 other slot kept");
    endtask

    task automatic t_reset_recall();
        issue(1, 1, 0, 8'h77, 1'b1, "R2 write before reset");
        do_reset();
        for (int q = 0; q < 4; q++) issue(2, q, 2, 8'h00, 1'b1, "R1 slot kept over reset");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_dr[i] = 8'(8'hA0 + i);
        @(negedge clk);
        do_reset();
        t_wcr_rw();
        t_dr_write_busy();
        t_reject_and_edge();
        t_load_store();
        t_global();
        t_reset_recall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule